// File: doc/BRIEF.md
# PCI Configuration Cycle Router

This block sits on the host side of a PCI bridge and turns processor I/O accesses into PCI configuration cycles. It holds a 32-bit configuration address register and opens a 4-byte data window. Each access to that window is classified by the bus number held in the address register. Bus zero goes to a device on the local bus. A bus number equal to the bridge's secondary bus becomes a Type 0 cycle on that bus. A bus number further down the hierarchy, within the programmed secondary-to-subordinate range, becomes a Type 1 cycle. Any other bus number is answered locally and never reaches a bus.

For every access that is routed, the block produces a one-cycle launch strobe. With it come the route code, the cycle type, the AD[31:0] address-phase word, and the direction, byte enables and write data. Read data for a routed access is taken from the downstream side in the same cycle. Read data for an access that is not routed is all ones.

Top module: `cfg_cycle_router`

## Requirements
- R1: The address register is written only by a write to I/O port 0xCF8 with all four byte enables set. A write to 0xCF8 with any other byte-enable pattern leaves the register unchanged.
- R2: A full-dword read of port 0xCF8 returns the address register in the same cycle. Bit 31 is the enable, bits 23:16 the bus, bits 15:11 the device, bits 10:8 the function and bits 7:2 the register index. Bits 30:24 and 1:0 always read as zero.
- R3: While address bit 31 is clear, an access to the data window (ports 0xCFC to 0xCFF) launches no cycle, and a read of the window returns 0xFFFFFFFF.
- R4: With the enable set and bus number 0, a window access launches a cycle with route code 1 (local) and cycle type 0.
- R5: With a non-zero bus number equal to the secondary bus number, route code 2 is used with cycle type 0. AD[11+d] is set for device d up to 20, and no device-select bit is set for d above 20. AD[10:8] holds the function, AD[7:2] the register index, and AD[1:0] is 00.
- R6: With a bus number above the secondary bus and not above the subordinate bus, route code 3 is used with cycle type 1. AD[31:24] is zero, AD[23:2] repeats the bus, device, function and register fields at their address-register positions, and AD[1:0] is 01.
- R7: A non-zero bus number outside those cases launches no cycle. Reads of it return 0xFFFFFFFF and writes to it are dropped. After reset the secondary and subordinate numbers are 0, so no non-zero bus is routed.
- R8: After reset the address register reads as zero and no cycle is launched.
- R9: A routed window access raises cyc_valid for exactly the next cycle. That cycle carries the direction, byte enables and write data of the access, and cyc_valid falls again if no further access follows. A routed read returns cyc_rdata combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| io_rd | input | 1 | I/O read strobe, one cycle per access |
| io_addr | input | 16 | I/O port address |
| io_be | input | 4 | Byte enables of the access |
| io_wdata | input | 32 | I/O write data |
| io_rdata | output | 32 | I/O read data, valid in the cycle of io_rd |
| sec_bus | input | 8 | Programmed secondary bus number |
| sub_bus | input | 8 | Programmed subordinate bus number |
| cyc_rdata | input | 32 | Read data returned by the target bus for a routed read |
| cyc_valid | output | 1 | Launch strobe of a configuration cycle |
| cyc_route | output | 2 | Route code: 1 local, 2 secondary Type 0, 3 downstream Type 1 |
| cyc_type1 | output | 1 | Cycle is Type 1 |
| cyc_ad | output | 32 | Address-phase word AD[31:0] |
| cyc_write | output | 1 | Cycle is a write |
| cyc_be | output | 4 | Byte enables of the cycle |
| cyc_wdata | output | 32 | Write data of the cycle |

## Verification
The checker assumes that io_wr and io_rd are never high together. It also assumes that sec_bus and sub_bus change only when no window access is in flight, because the Type 1 range check compares the launched bus against the bounds of the previous cycle. The bench drives exactly one strobe per access. It changes the bus-number inputs only between accesses, on idle cycles, and keeps the secondary number at or below the subordinate number.

// File: rtl/cfg_router_pkg.sv
package cfg_router_pkg;

  localparam int BUS_W     = 8;
  localparam int DEV_W     = 5;
  localparam int FUNC_W    = 3;
  localparam int REG_W     = 6;
  localparam int RSVD_W    = 7;
  localparam int IDSEL_LSB = 11;
  localparam logic [31:0] ADDR_KEEP_MASK = 32'h80FF_FFFC;

  typedef enum logic [1:0] {
    RT_NONE       = 2'd0,
    RT_LOCAL      = 2'd1,
    RT_SECONDARY  = 2'd2,
    RT_DOWNSTREAM = 2'd3
  } route_e;

  typedef struct packed {
    logic              en;
    logic [RSVD_W-1:0] rsvd;
    logic [BUS_W-1:0]  bus;
    logic [DEV_W-1:0]  dev;
    logic [FUNC_W-1:0] func;
    logic [REG_W-1:0]  reg_idx;
    logic [1:0]        lo;
  } cfg_addr_t;

  // Routing decision; bus 0 wins over a secondary number of 0.
  function automatic route_e classify(input cfg_addr_t a,
                                      input logic [BUS_W-1:0] sec,
                                      input logic [BUS_W-1:0] sub);
    route_e r;
    if (!a.en)                          r = RT_NONE;
    else if (a.bus == '0)               r = RT_LOCAL;
    else if (a.bus == sec)              r = RT_SECONDARY;
    else if (a.bus > sec && a.bus <= sub) r = RT_DOWNSTREAM;
    else                                r = RT_NONE;
    return r;
  endfunction

  // Type 0 word: one-hot device select above IDSEL_LSB, then func/reg.
  function automatic logic [31:0] type0_ad(input cfg_addr_t a);
    logic [31:0] ad;
    ad = '0;
    for (int i = IDSEL_LSB; i < 32; i++) begin
      ad[i] = ((i - IDSEL_LSB) == int'(a.dev));
    end
    ad[10:8] = a.func;
    ad[7:2]  = a.reg_idx;
    ad[1:0]  = 2'b00;
    return ad;
  endfunction

  // Type 1 word: fields kept in place, low pair marks the cycle type.
  function automatic logic [31:0] type1_ad(input cfg_addr_t a);
    return {8'h00, a.bus, a.dev, a.func, a.reg_idx, 2'b01};
  endfunction

endpackage

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg
  import cfg_router_pkg::*;
#(
  parameter int               ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] ADDR_PORT = 16'hCF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [3:0]        io_be,
  input  logic [31:0]       io_wdata,
  output logic              addr_wr_hit,
  output cfg_addr_t         addr_q
);

  assign addr_wr_hit = io_wr && (io_addr == ADDR_PORT) && (io_be == 4'hF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_wr_hit) begin
      addr_q <= cfg_addr_t'(io_wdata & ADDR_KEEP_MASK);
    end
  end

endmodule

// File: rtl/cfg_route_decode.sv
module cfg_route_decode
  import cfg_router_pkg::*;
(
  input  cfg_addr_t        addr_q,
  input  logic [BUS_W-1:0] sec_bus,
  input  logic [BUS_W-1:0] sub_bus,
  output route_e           route_nxt,
  output logic             type1_nxt,
  output logic [31:0]      ad_nxt
);

  always_comb begin
    route_nxt = classify(addr_q, sec_bus, sub_bus);
    type1_nxt = (route_nxt == RT_DOWNSTREAM);
    ad_nxt    = type1_nxt ? type1_ad(addr_q) : type0_ad(addr_q);
  end

endmodule

// File: rtl/cfg_cycle_gen.sv
module cfg_cycle_gen
  import cfg_router_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        launch,
  input  route_e      route_nxt,
  input  logic        type1_nxt,
  input  logic [31:0] ad_nxt,
  input  logic        io_wr,
  input  logic [3:0]  io_be,
  input  logic [31:0] io_wdata,
  output logic        cyc_valid,
  output route_e      cyc_route,
  output logic        cyc_type1,
  output logic [31:0] cyc_ad,
  output logic        cyc_write,
  output logic [3:0]  cyc_be,
  output logic [31:0] cyc_wdata
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_valid <= 1'b0;
      cyc_route <= RT_NONE;
      cyc_type1 <= 1'b0;
      cyc_ad    <= '0;
      cyc_write <= 1'b0;
      cyc_be    <= '0;
      cyc_wdata <= '0;
    end else begin
      cyc_valid <= launch;
      if (launch) begin
        cyc_route <= route_nxt;
        cyc_type1 <= type1_nxt;
        cyc_ad    <= ad_nxt;
        cyc_write <= io_wr;
        cyc_be    <= io_be;
        cyc_wdata <= io_wdata;
      end
    end
  end

endmodule

// File: rtl/cfg_cycle_router.sv
module cfg_cycle_router
  import cfg_router_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] ADDR_PORT = 16'hCF8,
  parameter logic [ADDR_W-1:0] DATA_PORT = 16'hCFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [3:0]        io_be,
  input  logic [31:0]       io_wdata,
  output logic [31:0]       io_rdata,
  input  logic [7:0]        sec_bus,
  input  logic [7:0]        sub_bus,
  input  logic [31:0]       cyc_rdata,
  output logic              cyc_valid,
  output logic [1:0]        cyc_route,
  output logic              cyc_type1,
  output logic [31:0]       cyc_ad,
  output logic              cyc_write,
  output logic [3:0]        cyc_be,
  output logic [31:0]       cyc_wdata
);

  localparam int WIN_MSB = ADDR_W - 1;

  // Named internal events, also observed by the checker.
  cfg_addr_t   addr_q;
  logic        addr_wr_hit;
  logic        addr_rd_hit;
  logic        win_hit;
  logic        win_acc;
  logic        launch;
  route_e      route_nxt;
  logic        type1_nxt;
  logic [31:0] ad_nxt;
  route_e      route_q;

  assign addr_rd_hit = io_rd && (io_addr == ADDR_PORT) && (io_be == 4'hF);
  assign win_hit     = (io_addr[WIN_MSB:2] == DATA_PORT[WIN_MSB:2]);
  assign win_acc     = (io_wr || io_rd) && win_hit;
  assign launch      = win_acc && (route_nxt != RT_NONE);

  cfg_addr_reg #(
    .ADDR_W   (ADDR_W),
    .ADDR_PORT(ADDR_PORT)
  ) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_wr      (io_wr),
    .io_addr    (io_addr),
    .io_be      (io_be),
    .io_wdata   (io_wdata),
    .addr_wr_hit(addr_wr_hit),
    .addr_q     (addr_q)
  );

  cfg_route_decode u_dec (
    .addr_q   (addr_q),
    .sec_bus  (sec_bus),
    .sub_bus  (sub_bus),
    .route_nxt(route_nxt),
    .type1_nxt(type1_nxt),
    .ad_nxt   (ad_nxt)
  );

  cfg_cycle_gen u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .route_nxt(route_nxt),
    .type1_nxt(type1_nxt),
    .ad_nxt   (ad_nxt),
    .io_wr    (io_wr),
    .io_be    (io_be),
    .io_wdata (io_wdata),
    .cyc_valid(cyc_valid),
    .cyc_route(route_q),
    .cyc_type1(cyc_type1),
    .cyc_ad   (cyc_ad),
    .cyc_write(cyc_write),
    .cyc_be   (cyc_be),
    .cyc_wdata(cyc_wdata)
  );

  assign cyc_route = route_q;

  always_comb begin
    if (addr_rd_hit)              io_rdata = addr_q;
    else if (io_rd && launch)     io_rdata = cyc_rdata;
    else                          io_rdata = 32'hFFFF_FFFF;
  end

endmodule

// File: rtl/cfg_router_chk.sv
module cfg_router_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        io_wr,
  input logic        io_rd,
  input logic [31:0] io_rdata,
  input logic [7:0]  sec_bus,
  input logic [7:0]  sub_bus,
  input logic [31:0] addr_q,
  input logic        addr_wr_hit,
  input logic        win_acc,
  input logic        launch,
  input logic [1:0]  route_nxt,
  input logic        cyc_valid,
  input logic        cyc_type1,
  input logic [1:0]  cyc_route,
  input logic [31:0] cyc_ad
);

  p_resv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_q[30:24] == 7'd0) && (addr_q[1:0] == 2'd0));

  p_addr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_wr_hit |=> $stable(addr_q));

  p_no_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_acc && !addr_q[31]) |=> !cyc_valid);

  p_launch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> cyc_valid);

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !launch |=> !cyc_valid);

  p_type0_ad_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !cyc_type1) |-> (cyc_ad[1:0] == 2'b00) && $onehot0(cyc_ad[31:11]));

  p_type1_ad_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_type1) |-> (cyc_ad[1:0] == 2'b01) && (cyc_route == 2'd3)
      && (cyc_ad[23:16] > $past(sec_bus)) && (cyc_ad[23:16] <= $past(sub_bus)));

  p_discard_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && win_acc && route_nxt == 2'd0) |-> io_rdata == 32'hFFFF_FFFF);

  p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && io_rd));

endmodule

bind cfg_cycle_router cfg_router_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .io_wr      (io_wr),
  .io_rd      (io_rd),
  .io_rdata   (io_rdata),
  .sec_bus    (sec_bus),
  .sub_bus    (sub_bus),
  .addr_q     (addr_q),
  .addr_wr_hit(addr_wr_hit),
  .win_acc    (win_acc),
  .launch     (launch),
  .route_nxt  (route_nxt),
  .cyc_valid  (cyc_valid),
  .cyc_type1  (cyc_type1),
  .cyc_route  (cyc_route),
  .cyc_ad     (cyc_ad)
);

// File: tb/sim_cfg_cycle_router.sv
module sim_cfg_cycle_router;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [15:0] io_addr = '0;
  logic [3:0]  io_be = '0;
  logic [31:0] io_wdata = '0;
  logic [31:0] io_rdata;
  logic [7:0]  sec_bus = '0;
  logic [7:0]  sub_bus = '0;
  logic [31:0] cyc_rdata = 32'h1234_5678;
  logic        cyc_valid;
  logic [1:0]  cyc_route;
  logic        cyc_type1;
  logic [31:0] cyc_ad;
  logic        cyc_write;
  logic [3:0]  cyc_be;
  logic [31:0] cyc_wdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Values captured after each access
  logic [31:0] got_rd;
  logic        got_v;
  logic [1:0]  got_route;
  logic        got_t1;
  logic [31:0] got_ad;
  logic        got_w;
  logic [3:0]  got_be;
  logic [31:0] got_wd;

  always #4 clk = ~clk;

  cfg_cycle_router u0 (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_be(io_be), .io_wdata(io_wdata), .io_rdata(io_rdata), .sec_bus(sec_bus),
    .sub_bus(sub_bus), .cyc_rdata(cyc_rdata), .cyc_valid(cyc_valid),
    .cyc_route(cyc_route), .cyc_type1(cyc_type1), .cyc_ad(cyc_ad),
    .cyc_write(cyc_write), .cyc_be(cyc_be), .cyc_wdata(cyc_wdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One access; starts and ends at a falling edge.
  task automatic acc(input logic wr, input logic [15:0] a, input logic [3:0] be,
                     input logic [31:0] d);
    io_wr = wr; io_rd = !wr; io_addr = a; io_be = be; io_wdata = d;
    #1 got_rd = io_rdata;
    @(posedge clk); #1;
    got_v = cyc_valid; got_route = cyc_route; got_t1 = cyc_type1; got_ad = cyc_ad;
    got_w = cyc_write; got_be = cyc_be; got_wd = cyc_wdata;
    @(negedge clk);
    io_wr = 0; io_rd = 0; io_addr = '0; io_be = '0; io_wdata = '0;
  endtask

  function automatic logic [31:0] addr_word(input bit en, input int bus, input int dev,
                                            input int fn, input int rg);
    return (en ? 32'h8000_0000 : 32'h0) + (bus << 16) + (dev << 11) + (fn << 8) + (rg << 2);
  endfunction

  function automatic logic [31:0] exp_t0(input int dev, input int fn, input int rg);
    logic [31:0] sel;
    sel = (dev <= 20) ? (32'h1 << (11 + dev)) : 32'h0;
    return sel | (fn << 8) | (rg << 2);
  endfunction

  function automatic logic [31:0] exp_t1(input int bus, input int dev, input int fn, input int rg);
    return (bus * 65536) + (dev * 2048) + (fn * 256) + (rg * 4) + 1;
  endfunction

  task automatic t_reset;
    chk("R8 cyc_valid after reset", {31'd0, cyc_valid}, 32'd0);
    acc(0, 16'hCF8, 4'hF, 0);
    chk("R8 address register after reset", got_rd, 32'd0);
  endtask

  task automatic t_addr_reg;
    acc(1, 16'hCF8, 4'hF, 32'hFFFF_FFFF);
    acc(0, 16'hCF8, 4'hF, 0);
    chk("R2 reserved bits read zero", got_rd, 32'h80FF_FFFC);
    acc(1, 16'hCF8, 4'h3, 32'h0);
    acc(0, 16'hCF8, 4'hF, 0);
    chk("R1 partial write ignored", got_rd, 32'h80FF_FFFC);
    acc(1, 16'hCF8, 4'hF, addr_word(1, 7, 9, 2, 5) | 32'h7F00_0003);
    acc(0, 16'hCF8, 4'hF, 0);
    chk("R2 field readback", got_rd, addr_word(1, 7, 9, 2, 5));
  endtask

  task automatic t_disabled;
    acc(1, 16'hCF8, 4'hF, addr_word(0, 0, 3, 1, 4));
    acc(0, 16'hCFC, 4'hF, 0);
    chk("R3 disabled read ones", got_rd, 32'hFFFF_FFFF);
    chk("R3 disabled no cycle", {31'd0, got_v}, 32'd0);
  endtask

  task automatic t_reset_range;
    acc(1, 16'hCF8, 4'hF, addr_word(1, 1, 0, 0, 0));
    acc(0, 16'hCFC, 4'hF, 0);
    chk("R7 bus 1 unrouted at reset range", {31'd0, got_v}, 32'd0);
    chk("R7 bus 1 reads ones", got_rd, 32'hFFFF_FFFF);
  endtask

  task automatic t_local;
    acc(1, 16'hCF8, 4'hF, addr_word(1, 0, 3, 1, 16));
    acc(0, 16'hCFC, 4'hF, 0);
    chk("R9 routed read data", got_rd, 32'h1234_5678);
    chk("R4 valid", {31'd0, got_v}, 32'd1);
    chk("R4 route local", {30'd0, got_route}, 32'd1);
    chk("R4 type 0", {31'd0, got_t1}, 32'd0);
    chk("R4 ad", got_ad, exp_t0(3, 1, 16));
    @(posedge clk); #1;
    chk("R9 strobe falls", {31'd0, cyc_valid}, 32'd0);
    @(negedge clk);
  endtask

  task automatic t_secondary;
    acc(1, 16'hCF8, 4'hF, addr_word(1, 2, 20, 7, 63));
    acc(1, 16'hCFE, 4'b0100, 32'h00AB_0000);
    chk("R5 route secondary", {30'd0, got_route}, 32'd2);
    chk("R5 ad dev20", got_ad, exp_t0(20, 7, 63));
    chk("R9 write dir", {31'd0, got_w}, 32'd1);
    chk("R9 byte enables", {28'd0, got_be}, 32'h4);
    chk("R9 write data", got_wd, 32'h00AB_0000);
    acc(1, 16'hCF8, 4'hF, addr_word(1, 2, 21, 0, 1));
    acc(0, 16'hCFC, 4'hF, 0);
    chk("R5 ad dev21 no select", got_ad, exp_t0(21, 0, 1));
    chk("R5 type 0", {31'd0, got_t1}, 32'd0);
  endtask

  task automatic t_downstream;
    acc(1, 16'hCF8, 4'hF, addr_word(1, 3, 31, 5, 42));
    acc(0, 16'hCFC, 4'hF, 0);
    chk("R6 route downstream", {30'd0, got_route}, 32'd3);
    chk("R6 type 1", {31'd0, got_t1}, 32'd1);
    chk("R6 ad", got_ad, exp_t1(3, 31, 5, 42));
    acc(1, 16'hCF8, 4'hF, addr_word(1, 5, 0, 0, 0));
    acc(0, 16'hCFC, 4'hF, 0);
    chk("R6 upper bound routed", got_ad, exp_t1(5, 0, 0, 0));
    chk("R6 upper bound valid", {31'd0, got_v}, 32'd1);
  endtask

  task automatic t_outside;
    acc(1, 16'hCF8, 4'hF, addr_word(1, 6, 1, 0, 0));
    acc(0, 16'hCFC, 4'hF, 0);
    chk("R7 above subordinate reads ones", got_rd, 32'hFFFF_FFFF);
    chk("R7 above subordinate no cycle", {31'd0, got_v}, 32'd0);
    acc(1, 16'hCF8, 4'hF, addr_word(1, 1, 1, 0, 0));
    acc(1, 16'hCFC, 4'hF, 32'hDEAD_BEEF);
    chk("R7 below secondary write dropped", {31'd0, got_v}, 32'd0);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_addr_reg();
    t_disabled();
    t_reset_range();
    sec_bus = 8'd2; sub_bus = 8'd5;
    @(negedge clk);
    t_local();
    t_secondary();
    t_downstream();
    t_outside();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule